// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Exception States

This block is the hardwired controller of a multicycle 32-bit processor datapath. It steps each instruction through a series of one-cycle states. A fetch state and a decode state are common to every instruction. The decode state dispatches on the 6-bit opcode to a short per-class sequence: load word, store word, register-register ALU operation, branch-if-equal or jump. Every sequence ends back in fetch. Branch and jump take 3 cycles, ALU operations and stores take 4, and loads take 5.

Two extra states handle exceptions. The first is entered from decode when the opcode is not one of the five supported codes. The second is entered from the ALU execute state when the datapath reports signed overflow. In that case the result writeback is skipped. Both exception states do the same four things in a single cycle. They record a cause code, capture the faulting instruction address by having the ALU compute PC minus 4, steer the PC to the handler vector, and then return to fetch.

All datapath control outputs are a function of the current state alone. The next state depends on the state, the opcode and the overflow flag.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset `rst` places the sequencer in fetch. The fetch control word is present on the outputs in the cycle after the reset edge and stays there while `rst` is held.
- R2: The fetch state drives `mem_rd`=1, `ir_load`=1, `pc_load`=1, `a_from_reg`=0, `b_sel`=01 (constant 4), `alu_mode`=00 (add) and `pc_sel`=00 (ALU result), with every other output 0. Fetch is always followed by decode.
- R3: The decode state drives only `b_sel`=11 (shifted sign-extended offset), with `alu_mode`=00 and every other output 0. It dispatches as follows: opcode 0x00 to execute, 0x23 and 0x2B to address calculation, 0x04 to branch, 0x02 to jump, and any other opcode to the undefined-opcode exception.
- R4: A load (0x23) runs through five cycles: fetch, decode, address (`a_from_reg`=1, `b_sel`=10, `alu_mode`=00), memory read (`mem_rd`=1, `data_addr`=1), and writeback (`rf_we`=1, `dst_rd`=0, `wb_mem`=1). It then returns to fetch.
- R5: A store (0x2B) runs through four cycles: fetch, decode, address, and memory write (`mem_wr`=1, `data_addr`=1). It makes no register-file write.
- R6: An ALU instruction (0x00) without overflow runs through four cycles: fetch, decode, execute (`a_from_reg`=1, `b_sel`=00, `alu_mode`=10 meaning function field), and writeback (`rf_we`=1, `dst_rd`=1, `wb_mem`=0).
- R7: A branch (0x04) runs through three cycles. Its third cycle drives `a_from_reg`=1, `b_sel`=00, `alu_mode`=01 (subtract), `pc_cond`=1 and `pc_sel`=01 (ALUOut), with `pc_load`=0.
- R8: A jump (0x02) runs through three cycles. Its third cycle drives only `pc_load`=1 with `pc_sel`=10 (jump target).
- R9: An undefined opcode runs through three cycles. Its third cycle drives `pc_load`=1, `cause_we`=1, `epc_we`=1, `cause_code`=0, `a_from_reg`=0, `b_sel`=01, `alu_mode`=01 and `pc_sel`=11 (exception vector).
- R10: If `alu_ovf` is 1 in the execute state, the fourth cycle is the overflow exception state instead of writeback. That state has the same control word as R9 except `cause_code`=1, and it makes no register-file write. `alu_ovf` has no effect in any other state.
- R11: The outputs depend only on the current state. Changing `opcode` or `alu_ovf` within a cycle leaves the outputs unchanged.
- R12: `mem_rd` and `mem_wr` are never both 1. `pc_load` and `pc_cond` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_ovf | input | 1 | Signed overflow flag from the ALU |
| pc_load | output | 1 | Unconditional PC write |
| pc_cond | output | 1 | PC write qualified by the ALU zero flag |
| data_addr | output | 1 | Memory address taken from ALUOut instead of PC |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_load | output | 1 | Instruction register write |
| wb_mem | output | 1 | Register writeback data taken from the memory data register |
| dst_rd | output | 1 | Register destination taken from the rd field instead of rt |
| rf_we | output | 1 | Register file write |
| a_from_reg | output | 1 | ALU A operand from register A instead of PC |
| b_sel | output | 2 | ALU B operand: 00 reg B, 01 constant 4, 10 sign-extended offset, 11 offset shifted by 2 |
| alu_mode | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| pc_sel | output | 2 | PC source: 00 ALU result, 01 ALUOut, 10 jump target, 11 exception vector |
| cause_code | output | 1 | Exception cause: 0 undefined opcode, 1 overflow |
| cause_we | output | 1 | Cause register write |
| epc_we | output | 1 | Exception PC register write |

## Verification
A corrupted or misrouted state appears at the ports in the same cycle as a wrong control word. It also appears as a wrong instruction length, because the next `ir_load` comes early or late. The bench compares the exact word in every step of every instruction class. For each opcode and overflow combination it also counts the cycle length and the write strobes seen between fetches. A lost exception divert therefore shows up as a register write or a missing cause write within four cycles.

// File: rtl/mc_seq_ctrl_pkg.sv
package mc_seq_ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;

    localparam logic [OPC_W-1:0] OPC_ALU   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ADDR    = 4'd2,
        ST_LD_MEM  = 4'd3,
        ST_LD_WB   = 4'd4,
        ST_ST_MEM  = 4'd5,
        ST_EXEC    = 4'd6,
        ST_ALU_WB  = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9,
        ST_BAD_OP  = 4'd10,
        ST_OVF     = 4'd11
    } seq_state_e;

    typedef enum logic [1:0] {
        B_REG    = 2'b00,
        B_FOUR   = 2'b01,
        B_IMM    = 2'b10,
        B_IMM_SH = 2'b11
    } b_src_e;

    typedef enum logic [1:0] {
        AM_ADD   = 2'b00,
        AM_SUB   = 2'b01,
        AM_FUNCT = 2'b10,
        AM_RSVD  = 2'b11
    } alu_mode_e;

    typedef enum logic [1:0] {
        PS_ALU    = 2'b00,
        PS_ALUOUT = 2'b01,
        PS_JUMP   = 2'b10,
        PS_VECTOR = 2'b11
    } pc_src_e;

    typedef struct packed {
        logic      pc_load;
        logic      pc_cond;
        logic      data_addr;
        logic      mem_rd;
        logic      mem_wr;
        logic      ir_load;
        logic      wb_mem;
        logic      dst_rd;
        logic      rf_we;
        logic      a_from_reg;
        b_src_e    b_sel;
        alu_mode_e alu_mode;
        pc_src_e   pc_sel;
        logic      cause_code;
        logic      cause_we;
        logic      epc_we;
    } ctrl_word_t;

    function automatic logic opc_supported(logic [OPC_W-1:0] op);
        return (op == OPC_ALU) || (op == OPC_LOAD) || (op == OPC_STORE) ||
               (op == OPC_BEQ) || (op == OPC_JUMP);
    endfunction

endpackage

// File: rtl/mc_seq_next.sv
module mc_seq_next
    import mc_seq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_ovf,
    output seq_state_e       state
);

    seq_state_e nxt;

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OPC_ALU)                               nxt = ST_EXEC;
                else if (opcode == OPC_LOAD || opcode == OPC_STORE)  nxt = ST_ADDR;
                else if (opcode == OPC_BEQ)                          nxt = ST_BRANCH;
                else if (opcode == OPC_JUMP)                         nxt = ST_JUMP;
                else                                                 nxt = ST_BAD_OP;
            end
            ST_ADDR:   nxt = (opcode == OPC_LOAD) ? ST_LD_MEM : ST_ST_MEM;
            ST_LD_MEM: nxt = ST_LD_WB;
            ST_EXEC:   nxt = alu_ovf ? ST_OVF : ST_ALU_WB;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    // R2: fetch is always followed by decode
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    // R9: unsupported opcode in decode enters the undefined-opcode state
    a_r9_bad_opcode: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && !opc_supported(opcode)) |=> (state == ST_BAD_OP));

    // R10: overflow in execute skips writeback
    a_r10_ovf_divert: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && alu_ovf) |=> (state == ST_OVF));

    // R4: load memory read is followed by load writeback
    a_r4_load_order: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LD_MEM) |=> (state == ST_LD_WB));

endmodule

// File: rtl/mc_seq_out.sv
module mc_seq_out
    import mc_seq_ctrl_pkg::*;
(
    input  seq_state_e state,
    output ctrl_word_t cw
);

    always_comb begin
        cw = '0;
        unique case (state)
            ST_FETCH: begin
                cw.mem_rd   = 1'b1;
                cw.ir_load  = 1'b1;
                cw.pc_load  = 1'b1;
                cw.b_sel    = B_FOUR;
                cw.alu_mode = AM_ADD;
                cw.pc_sel   = PS_ALU;
            end
            ST_DECODE: begin
                cw.b_sel    = B_IMM_SH;
                cw.alu_mode = AM_ADD;
            end
            ST_ADDR: begin
                cw.a_from_reg = 1'b1;
                cw.b_sel      = B_IMM;
                cw.alu_mode   = AM_ADD;
            end
            ST_LD_MEM: begin
                cw.mem_rd    = 1'b1;
                cw.data_addr = 1'b1;
            end
            ST_LD_WB: begin
                cw.rf_we  = 1'b1;
                cw.wb_mem = 1'b1;
            end
            ST_ST_MEM: begin
                cw.mem_wr    = 1'b1;
                cw.data_addr = 1'b1;
            end
            ST_EXEC: begin
                cw.a_from_reg = 1'b1;
                cw.b_sel      = B_REG;
                cw.alu_mode   = AM_FUNCT;
            end
            ST_ALU_WB: begin
                cw.rf_we  = 1'b1;
                cw.dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                cw.a_from_reg = 1'b1;
                cw.b_sel      = B_REG;
                cw.alu_mode   = AM_SUB;
                cw.pc_cond    = 1'b1;
                cw.pc_sel     = PS_ALUOUT;
            end
            ST_JUMP: begin
                cw.pc_load = 1'b1;
                cw.pc_sel  = PS_JUMP;
            end
            ST_BAD_OP, ST_OVF: begin
                cw.pc_load    = 1'b1;
                cw.cause_we   = 1'b1;
                cw.epc_we     = 1'b1;
                cw.cause_code = (state == ST_OVF);
                cw.b_sel      = B_FOUR;
                cw.alu_mode   = AM_SUB;
                cw.pc_sel     = PS_VECTOR;
            end
            default: cw = '0;
        endcase
    end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
    import mc_seq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_ovf,
    output logic             pc_load,
    output logic             pc_cond,
    output logic             data_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_load,
    output logic             wb_mem,
    output logic             dst_rd,
    output logic             rf_we,
    output logic             a_from_reg,
    output logic [1:0]       b_sel,
    output logic [1:0]       alu_mode,
    output logic [1:0]       pc_sel,
    output logic             cause_code,
    output logic             cause_we,
    output logic             epc_we
);

    seq_state_e state;
    ctrl_word_t cw;

    mc_seq_next u_next (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode),
        .alu_ovf (alu_ovf),
        .state   (state)
    );

    mc_seq_out u_out (
        .state (state),
        .cw    (cw)
    );

    assign pc_load    = cw.pc_load;
    assign pc_cond    = cw.pc_cond;
    assign data_addr  = cw.data_addr;
    assign mem_rd     = cw.mem_rd;
    assign mem_wr     = cw.mem_wr;
    assign ir_load    = cw.ir_load;
    assign wb_mem     = cw.wb_mem;
    assign dst_rd     = cw.dst_rd;
    assign rf_we      = cw.rf_we;
    assign a_from_reg = cw.a_from_reg;
    assign b_sel      = cw.b_sel;
    assign alu_mode   = cw.alu_mode;
    assign pc_sel     = cw.pc_sel;
    assign cause_code = cw.cause_code;
    assign cause_we   = cw.cause_we;
    assign epc_we     = cw.epc_we;

    // R1: first cycle after reset release shows the fetch word
    a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ir_load && mem_rd && pc_load));

    // R12: memory read and write are exclusive
    a_r12_mem_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R12: unconditional and conditional PC writes are exclusive
    a_r12_pc_excl: assert property (@(posedge clk) disable iff (rst)
        !(pc_load && pc_cond));

    // R9 / R10: an exception cycle is followed by a fetch
    a_r9_exc_returns: assert property (@(posedge clk) disable iff (rst)
        cause_we |=> ir_load);

    // R10: the overflow exception cycle never writes the register file
    a_r10_no_rf_on_exc: assert property (@(posedge clk) disable iff (rst)
        (cause_we && cause_code) |-> (!rf_we && $past(!rf_we)));

endmodule

// File: tb/mc_seq_ctrl_tb_top.sv
module mc_seq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] opcode;
    logic       alu_ovf;
    logic pc_load, pc_cond, data_addr, mem_rd, mem_wr, ir_load, wb_mem, dst_rd, rf_we, a_from_reg;
    logic [1:0] b_sel, alu_mode, pc_sel;
    logic cause_code, cause_we, epc_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf),
        .pc_load(pc_load), .pc_cond(pc_cond), .data_addr(data_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
        .wb_mem(wb_mem), .dst_rd(dst_rd), .rf_we(rf_we),
        .a_from_reg(a_from_reg), .b_sel(b_sel), .alu_mode(alu_mode),
        .pc_sel(pc_sel), .cause_code(cause_code), .cause_we(cause_we),
        .epc_we(epc_we)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit viol     = 0;

    function automatic logic [18:0] mk(input logic pl, pc, da, mr, mw, il, wm, dr, rw, ar,
                                       input logic [1:0] bs, am, ps,
                                       input logic cc, cwe, ewe);
        return {pl, pc, da, mr, mw, il, wm, dr, rw, ar, bs, am, ps, cc, cwe, ewe};
    endfunction

    function automatic logic [18:0] word();
        return {pc_load, pc_cond, data_addr, mem_rd, mem_wr, ir_load, wb_mem, dst_rd,
                rf_we, a_from_reg, b_sel, alu_mode, pc_sel, cause_code, cause_we, epc_we};
    endfunction

    localparam logic [18:0] W_FETCH = mk(1,0,0,1,0,1,0,0,0,0,2'b01,2'b00,2'b00,0,0,0);
    localparam logic [18:0] W_DEC   = mk(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00,0,0,0);
    localparam logic [18:0] W_ADDR  = mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00,0,0,0);
    localparam logic [18:0] W_LDM   = mk(0,0,1,1,0,0,0,0,0,0,2'b00,2'b00,2'b00,0,0,0);
    localparam logic [18:0] W_LWB   = mk(0,0,0,0,0,0,1,0,1,0,2'b00,2'b00,2'b00,0,0,0);
    localparam logic [18:0] W_STM   = mk(0,0,1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00,0,0,0);
    localparam logic [18:0] W_EXEC  = mk(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00,0,0,0);
    localparam logic [18:0] W_RWB   = mk(0,0,0,0,0,0,0,1,1,0,2'b00,2'b00,2'b00,0,0,0);
    localparam logic [18:0] W_BEQ   = mk(0,1,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01,0,0,0);
    localparam logic [18:0] W_JMP   = mk(1,0,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10,0,0,0);
    localparam logic [18:0] W_EXC0  = mk(1,0,0,0,0,0,0,0,0,0,2'b01,2'b01,2'b11,0,1,1);
    localparam logic [18:0] W_EXC1  = mk(1,0,0,0,0,0,0,0,0,0,2'b01,2'b01,2'b11,1,1,1);

    typedef struct packed {
        logic [5:0] op;
        logic       ovf;
        logic [3:0] len;
        logic [1:0] n_rf;
        logic [1:0] n_mw;
        logic [1:0] n_mr;
        logic [1:0] n_exc;
        logic       cause;
        logic [1:0] n_cond;
        logic [1:0] n_jmp;
        logic [1:0] wbsel;
    } vec_t;

    // op, ovf, len, rf, mw, mr, exc, cause, cond, jmp, {dst_rd,wb_mem}
    localparam vec_t VECS [NV] = '{
        '{6'h23, 1'b0, 4'd5, 2'd1, 2'd0, 2'd2, 2'd0, 1'b0, 2'd0, 2'd0, 2'b01},
        '{6'h23, 1'b1, 4'd5, 2'd1, 2'd0, 2'd2, 2'd0, 1'b0, 2'd0, 2'd0, 2'b01},
        '{6'h2B, 1'b0, 4'd4, 2'd0, 2'd1, 2'd1, 2'd0, 1'b0, 2'd0, 2'd0, 2'b00},
        '{6'h00, 1'b0, 4'd4, 2'd1, 2'd0, 2'd1, 2'd0, 1'b0, 2'd0, 2'd0, 2'b10},
        '{6'h00, 1'b1, 4'd4, 2'd0, 2'd0, 2'd1, 2'd1, 1'b1, 2'd0, 2'd0, 2'b00},
        '{6'h04, 1'b0, 4'd3, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 2'd1, 2'd0, 2'b00},
        '{6'h04, 1'b1, 4'd3, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 2'd1, 2'd0, 2'b00},
        '{6'h02, 1'b0, 4'd3, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 2'd0, 2'd1, 2'b00},
        '{6'h3F, 1'b0, 4'd3, 2'd0, 2'd0, 2'd1, 2'd1, 1'b0, 2'd0, 2'd0, 2'b00},
        '{6'h08, 1'b1, 4'd3, 2'd0, 2'd0, 2'd1, 2'd1, 1'b0, 2'd0, 2'd0, 2'b00}
    };

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R4";
            1:       return "R4 R10";
            2:       return "R5";
            3:       return "R6";
            4:       return "R10";
            5, 6:    return "R7";
            7:       return "R8";
            default: return "R9";
        endcase
    endfunction

    logic [18:0] seen [0:7];
    int g_len, g_rf, g_mw, g_mr, g_exc, g_cond, g_jmp;
    logic g_cause;
    logic [1:0] g_wb;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic run_instr(input logic [5:0] op, input logic ov, input bit probe);
        int c = 0;
        logic [18:0] wd;
        opcode = op; alu_ovf = ov;
        g_rf = 0; g_mw = 0; g_mr = 0; g_exc = 0; g_cond = 0; g_jmp = 0;
        g_cause = 1'b0; g_wb = 2'b00;
        forever begin
            wd = word();
            seen[c] = wd;
            if (mem_rd && mem_wr) viol = 1;
            if (pc_load && pc_cond) viol = 1;
            if (rf_we)    begin g_rf++; g_wb = {dst_rd, wb_mem}; end
            if (mem_wr)   g_mw++;
            if (mem_rd)   g_mr++;
            if (cause_we) begin g_exc++; g_cause = cause_code; end
            if (pc_cond)  g_cond++;
            if (pc_load && pc_sel == 2'b10) g_jmp++;
            if (probe) begin
                opcode = ~op; alu_ovf = ~ov; #1;
                chk("R11 outputs moved with inputs", {13'd0, word()}, {13'd0, wd});
                opcode = op; alu_ovf = ov; #1;
            end
            c++;
            @(negedge clk);
            if (ir_load || c >= 8) break;
        end
        g_len = c;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; opcode = 6'h00; alu_ovf = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 word in reset", {13'd0, word()}, {13'd0, W_FETCH});
        rst = 1'b0;
        chk("R1 word at release", {13'd0, word()}, {13'd0, W_FETCH});

        // table walk: lengths and strobe counts per instruction class
        for (int i = 0; i < NV; i++) begin
            run_instr(VECS[i].op, VECS[i].ovf, 1'b0);
            chk({tag_of(i), " length"},     g_len,   VECS[i].len);
            chk({tag_of(i), " rf writes"},  g_rf,    VECS[i].n_rf);
            chk({tag_of(i), " mem writes"}, g_mw,    VECS[i].n_mw);
            chk({tag_of(i), " mem reads"},  g_mr,    VECS[i].n_mr);
            chk({tag_of(i), " exceptions"}, g_exc,   VECS[i].n_exc);
            chk({tag_of(i), " cond pc"},    g_cond,  VECS[i].n_cond);
            chk({tag_of(i), " jumps"},      g_jmp,   VECS[i].n_jmp);
            if (VECS[i].n_exc != 0) chk({tag_of(i), " cause"}, g_cause, VECS[i].cause);
            if (VECS[i].n_rf != 0)  chk({tag_of(i), " wb select"}, g_wb, VECS[i].wbsel);
        end

        // directed: exact control words per step
        run_instr(6'h23, 1'b0, 1'b0);
        chk("R2 fetch word",  seen[0], W_FETCH);
        chk("R3 decode word", seen[1], W_DEC);
        chk("R4 address",     seen[2], W_ADDR);
        chk("R4 mem read",    seen[3], W_LDM);
        chk("R4 writeback",   seen[4], W_LWB);
        run_instr(6'h2B, 1'b0, 1'b0);
        chk("R5 address",     seen[2], W_ADDR);
        chk("R5 mem write",   seen[3], W_STM);
        run_instr(6'h00, 1'b0, 1'b1);
        chk("R6 execute",     seen[2], W_EXEC);
        chk("R6 writeback",   seen[3], W_RWB);
        run_instr(6'h04, 1'b0, 1'b0);
        chk("R7 branch",      seen[2], W_BEQ);
        run_instr(6'h02, 1'b0, 1'b0);
        chk("R8 jump",        seen[2], W_JMP);
        run_instr(6'h3F, 1'b0, 1'b0);
        chk("R9 undefined",   seen[2], W_EXC0);
        run_instr(6'h00, 1'b1, 1'b0);
        chk("R10 exec",       seen[2], W_EXEC);
        chk("R10 overflow",   seen[3], W_EXC1);
        chk("R10 back to fetch", {13'd0, word()}, {13'd0, W_FETCH});

        // directed: reset in the middle of a load
        opcode = 6'h23; alu_ovf = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 mid-load address", {13'd0, word()}, {13'd0, W_ADDR});
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-instruction", {13'd0, word()}, {13'd0, W_FETCH});
        rst = 1'b0;
        run_instr(6'h23, 1'b0, 1'b0);
        chk("R1 recovery length", g_len, 5);

        chk("R12 exclusive strobes", {31'd0, viol}, 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule